// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block produces a slow sample or frame clock from a faster input clock. A divide field picks the output period in whole input-clock cycles. A high-time field picks how many of those cycles the output stays high, so the duty cycle is set in steps of one input cycle. A divide field of zero does not divide at all. It stops the output, holds it low, and drops the active flag.

Both fields are taken only at the end of an output period. A change made in the middle of a period therefore cannot cut a pulse short or stretch it. A parameter selects a build with no high-time field. That build drives a fixed duty cycle that is as close to half as whole cycles allow, and it ignores the high-time input.

Top module: `frame_clk_div`

## Requirements
- R1: While reset is asserted (rst_ni low), clk_o and active_o are both low.
- R2: A divide value of 0 stops the output. clk_o stays low and active_o is low. If the block was running, the period in progress completes first, and active_o stays high until that period ends.
- R3: For a divide value v ≥ 1 and a high-time value h ≤ v, in the field-duty build, clk_o repeats with a period of v+1 input cycles. It is high for the first h+1 cycles of each period.
- R4: With the default 8-bit divide field, v = 255 gives the largest ratio of 256 cycles. With h = 127 the output is high for 128 of those cycles.
- R5: A divide value of 1 gives the smallest ratio. The period is 2 cycles, and with h = 0 the output is high for 1 of them.
- R6: When h ≥ v, the high time is clamped to the full period, and clk_o stays high for as long as the divider is enabled.
- R7: The divide and high-time inputs are sampled only in the last cycle of a period, or while the divider is stopped. A change made during a period first takes effect in the next period.
- R8: When a nonzero divide value is presented while the divider is stopped, clk_o and active_o are both high one cycle later. That first period starts from count zero and has the full programmed length.
- R9: In the fixed-duty build, clk_o is high for floor((v+1)/2) of every v+1 cycles. The high-time input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_val_i | input | DIV_W | Divide field: 0 stops the output, v ≥ 1 sets a period of v+1 |
| hi_val_i | input | DIV_W | High-time field: the output is high for h+1 cycles (ignored in the fixed-duty build) |
| clk_o | output | 1 | Divided clock, driven from a register |
| active_o | output | 1 | High while a nonzero divide value is in effect |

## Verification
On every cycle, the assertions check four things:
- the output is low whenever the divider is stopped or in reset;
- the period counter never passes the active divide value;
- the active divide value stays steady away from a period boundary;
- each period, including the first after a restart, opens with a high output at count zero.

Only the bench scenarios can show the rest. These are the measured high and period lengths for each setting, the clamp to a continuous high, and the rule that a mid-period change leaves the current period untouched. The same goes for the cycle-exact restart and the odd-ratio rounding of the fixed-duty build.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  // Selects how the high phase of each output period is sized.
  typedef enum logic {
    DUTY_FIELD = 1'b0,  // high time comes from the high-time input
    DUTY_HALF  = 1'b1   // high time is floor(period/2), input ignored
  } duty_mode_e;

endpackage

// File: rtl/fcd_period_ctr.sv
// Holds the active divide/high-time settings and the in-period counter.
// Settings are reloaded only at the last cycle of a period or while stopped.
module fcd_period_ctr #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] hi_i,
  output logic [DIV_W-1:0] div_n,
  output logic [DIV_W-1:0] hi_n,
  output logic [DIV_W-1:0] cnt_n,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] cnt_q
);

  logic [DIV_W-1:0] hi_q;
  logic             stopped;
  logic             last_cyc;
  logic             ld_en;

  always_comb begin
    stopped  = (div_q == '0);
    last_cyc = (cnt_q == div_q);
    ld_en    = stopped | last_cyc;
    div_n    = ld_en ? div_i : div_q;
    hi_n     = ld_en ? hi_i  : hi_q;
    cnt_n    = ld_en ? '0    : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      hi_q  <= '0;
    end else if (ld_en) begin
      div_q <= div_i;
      hi_q  <= hi_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/fcd_phase_gen.sv
// Decides the level of the next output cycle and registers it.
module fcd_phase_gen #(
  parameter int unsigned          DIV_W     = 8,
  parameter fcd_pkg::duty_mode_e  DUTY_MODE = fcd_pkg::DUTY_FIELD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_n,
  input  logic [DIV_W-1:0] hi_n,
  input  logic [DIV_W-1:0] cnt_n,
  output logic             clk_o
);

  logic level_n;
  logic level_q;

  generate
    if (DUTY_MODE == fcd_pkg::DUTY_HALF) begin : g_half
      logic [DIV_W:0] half_len;
      logic           unused_hi;
      assign unused_hi = ^hi_n;
      always_comb begin
        half_len = ({1'b0, div_n} + 1'b1) >> 1;
        level_n  = (div_n != '0) && ({1'b0, cnt_n} < half_len);
      end
    end else begin : g_field
      // cnt_n never exceeds div_n, so h >= v keeps the level high all period.
      always_comb begin
        level_n = (div_n != '0) && (cnt_n <= hi_n);
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level_n;
    end
  end

  assign clk_o = level_q;

endmodule

// File: rtl/frame_clk_div.sv
module frame_clk_div #(
  parameter int unsigned         DIV_W     = 8,
  parameter fcd_pkg::duty_mode_e DUTY_MODE = fcd_pkg::DUTY_FIELD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic [DIV_W-1:0] hi_val_i,
  output logic             clk_o,
  output logic             active_o
);

  logic [DIV_W-1:0] div_n;
  logic [DIV_W-1:0] hi_n;
  logic [DIV_W-1:0] cnt_n;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  fcd_period_ctr #(
    .DIV_W (DIV_W)
  ) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_val_i),
    .hi_i   (hi_val_i),
    .div_n  (div_n),
    .hi_n   (hi_n),
    .cnt_n  (cnt_n),
    .div_q  (div_q),
    .cnt_q  (cnt_q)
  );

  fcd_phase_gen #(
    .DIV_W     (DIV_W),
    .DUTY_MODE (DUTY_MODE)
  ) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_n  (div_n),
    .hi_n   (hi_n),
    .cnt_n  (cnt_n),
    .clk_o  (clk_o)
  );

  assign active_o = (div_q != '0);

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_o,
  input logic             active_o,
  input logic [DIV_W-1:0] div_q,
  input logic [DIV_W-1:0] cnt_q
);

  always @(posedge clk_i) begin
    if (rst_ni == 1'b0) begin
      p_reset_low_r1: assert (!clk_o && !active_o)
        else $error("output not low in reset");
    end
  end

  p_gate_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !clk_o);

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (cnt_q <= div_q));

  p_open_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && cnt_q == '0) |-> clk_o);

  p_hold_cfg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && cnt_q != div_q) |=> $stable(div_q));

  p_restart_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> (clk_o && cnt_q == '0));

endmodule

bind frame_clk_div fcd_checker #(.DIV_W(DIV_W)) u_fcd_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clk_o    (clk_o),
  .active_o (active_o),
  .div_q    (div_q),
  .cnt_q    (cnt_q)
);

// File: tb/frame_clk_div_test.sv
`timescale 1ns/1ps
module frame_clk_div_test;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;  // 250 MHz

  logic [W-1:0] div_a, hi_a, div_b, hi_b;
  logic clk_a, act_a, clk_b, act_b;

  frame_clk_div #(.DIV_W(W), .DUTY_MODE(fcd_pkg::DUTY_FIELD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .div_val_i(div_a), .hi_val_i(hi_a),
    .clk_o(clk_a), .active_o(act_a));

  frame_clk_div #(.DIV_W(W), .DUTY_MODE(fcd_pkg::DUTY_HALF)) uut_half (
    .clk_i(clk), .rst_ni(rst_n), .div_val_i(div_b), .hi_val_i(hi_b),
    .clk_o(clk_b), .active_o(act_b));

  int n_chk = 0;
  int n_bad = 0;
  int    q_hi[$];
  int    q_per[$];
  string q_tag[$];

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(bit s);
    return s ? clk_b : clk_a;
  endfunction

  // Driver side: queue the expected (high, period) of upcoming periods.
  task automatic expect_run(int hi, int per, int n, string tag);
    for (int i = 0; i < n; i++) begin
      q_hi.push_back(hi);
      q_per.push_back(per);
      q_tag.push_back(tag);
    end
  endtask

  task automatic sync_rise(bit s);
    logic prev;
    prev = pick(s);
    forever begin
      @(negedge clk);
      if (!prev && pick(s)) break;
      prev = pick(s);
    end
  endtask

  // Monitor side: entered on the first high sample of a period; leaves on
  // the first high sample of the next. Optionally changes div_a/hi_a at
  // cycle chg_at of the first period measured.
  task automatic consume(bit s, int n, int chg_at = -1, int cd = 0, int ch = 0);
    for (int i = 0; i < n; i++) begin
      int hi, lo, k, e_hi, e_per;
      string tg;
      hi = 1; lo = 0; k = 0;
      @(negedge clk); k++;
      if (i == 0 && k == chg_at) begin div_a = cd[W-1:0]; hi_a = ch[W-1:0]; end
      while (pick(s)) begin
        hi++; @(negedge clk); k++;
        if (i == 0 && k == chg_at) begin div_a = cd[W-1:0]; hi_a = ch[W-1:0]; end
      end
      while (!pick(s)) begin
        lo++; @(negedge clk); k++;
      end
      e_hi = q_hi.pop_front(); e_per = q_per.pop_front(); tg = q_tag.pop_front();
      check(hi == e_hi, {tg, " high length"}, hi, e_hi);
      check(hi + lo == e_per, {tg, " period"}, hi + lo, e_per);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    div_a = '0; hi_a = '0; div_b = '0; hi_b = '0;
    repeat (3) @(negedge clk);
    // R1: reset holds outputs low
    check(!clk_a && !act_a, "R1 reset field build", {clk_a, act_a}, 0);
    check(!clk_b && !act_b, "R1 reset half build", {clk_b, act_b}, 0);
    rst_n = 1'b1;
    // R2: divide value 0 keeps the output stopped
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!clk_a && !act_a, "R2 stopped", {clk_a, act_a}, 0);
    end

    // R8: leaving the stopped state starts high one cycle later
    div_a = 8'd5; hi_a = 8'd2;
    @(negedge clk);
    check(clk_a && act_a, "R8 first cycle high", {clk_a, act_a}, 3);
    expect_run(3, 6, 3, "R3/R8 v5 h2");
    consume(0, 3);

    // R5 + R7: change at a period start; the running period completes
    div_a = 8'd1; hi_a = 8'd0;
    expect_run(3, 6, 1, "R7 old period kept");
    expect_run(1, 2, 4, "R5 ratio 2");
    consume(0, 5);

    // R3 with another pattern
    div_a = 8'd9; hi_a = 8'd4;
    expect_run(1, 2, 1, "R7 old period kept");
    expect_run(5, 10, 2, "R3 v9 h4");
    consume(0, 3);

    // R7: change in the middle of a high phase
    expect_run(5, 10, 1, "R7 mid-period change");
    expect_run(2, 4, 3, "R3 v3 h1");
    consume(0, 4, 2, 3, 1);

    // R6: high time above the period clamps to continuous high
    div_a = 8'd3; hi_a = 8'd9;
    expect_run(2, 4, 1, "R7 old period kept");
    consume(0, 1);
    for (int i = 0; i < 12; i++) begin
      check(clk_a == 1'b1, "R6 clamp h>v", clk_a, 1);
      @(negedge clk);
    end
    hi_a = 8'd3;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      check(clk_a == 1'b1, "R6 clamp h=v", clk_a, 1);
      @(negedge clk);
    end

    // R4: largest ratio
    div_a = 8'd255; hi_a = 8'd127;
    sync_rise(0);
    expect_run(128, 256, 2, "R4 max ratio");
    consume(0, 2);

    // R2: stopping a running divider finishes the period first
    div_a = '0;
    @(negedge clk);
    check(act_a == 1'b1, "R2 active until period end", act_a, 1);
    repeat (258) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      check(!clk_a && !act_a, "R2 stopped after run", {clk_a, act_a}, 0);
      @(negedge clk);
    end

    // R9: fixed-duty build
    div_b = 8'd4; hi_b = 8'd0;
    @(negedge clk);
    check(clk_b && act_b, "R9 start high", {clk_b, act_b}, 3);
    expect_run(2, 5, 2, "R9 ratio 5");
    consume(1, 2);
    div_b = 8'd5;
    expect_run(2, 5, 1, "R9 old period kept");
    expect_run(3, 6, 2, "R9 ratio 6");
    consume(1, 3);
    div_b = 8'd1;
    expect_run(3, 6, 1, "R9 old period kept");
    expect_run(1, 2, 2, "R9 ratio 2");
    consume(1, 3);
    div_b = 8'd2; hi_b = 8'd200;
    expect_run(1, 2, 1, "R9 old period kept");
    expect_run(1, 3, 3, "R9 ratio 3, high-time ignored");
    consume(1, 4);

    summary();
    $finish;
  end

endmodule